// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block holds two identical down-counting timer channels behind a 32-bit memory-mapped register port. Each channel has a reload (divisor) register, a control word and a readable count. The control word carries a two-bit operation (load, hold, run) and a three-bit rate code. The rate code picks one of four externally supplied one-cycle tick enables, so all logic stays on the single system clock.

Each channel has a two-state machine. In `ST_STOPPED` the count is frozen. In `ST_RUNNING` the count steps down on each selected tick. The transitions are:
- `GO`: a RUN write, from stopped to running.
- `HALT`: a LOAD or HOLD write, from running to stopped.

A running channel whose count is 1 or 0 when its tick arrives reloads from the divisor and raises a one-cycle expiry. Expiries set bits in a shared raw status register, channel 0 in bit 0 and channel 1 in bit 1. A mask register and a write-one-to-acknowledge register reduce that status to one registered interrupt line.

Top module: `dual_interval_timer`

Register offsets are byte addresses on `bus_addr`:

| Offset | Register | Access |
|---|---|---|
| 0x00 | channel 0 divisor | write |
| 0x04 | channel 0 control | write |
| 0x08 | channel 0 count | read |
| 0x10 | channel 1 divisor | write |
| 0x14 | channel 1 control | write |
| 0x18 | channel 1 count | read |
| 0x20 | mask | read and write |
| 0x24 | acknowledge | write |
| 0x28 | raw status | read |
| 0x2C | masked status | read |

Control word fields:
- bits [1:0] are the operation: 0 is LOAD, 1 is HOLD, 2 is RUN, 3 is illegal.
- bits [4:2] are the rate code: codes 4, 5, 6 and 7 select `tick_en[0]`, `tick_en[1]`, `tick_en[2]` and `tick_en[3]`.

## Requirements
- R1: After reset both counts read 0, raw status (0x28) and mask (0x20) read 0, `irq` is low and both channels are stopped.
- R2: Writing a divisor (0x00 or 0x10) does not change the count. A control write with operation 0 (LOAD) copies the divisor into the count and stops the channel.
- R3: After a control write with operation 1 (HOLD), or after a LOAD, the count does not change on any tick.
- R4: After a control write with operation 2 (RUN), the count decreases by one on each cycle in which the tick enable selected by the rate code (4 to 7 map to `tick_en[0..3]`) is high. Other tick enables have no effect.
- R5: Rate codes 0 to 3 select no tick source, so a running channel with such a code never changes its count.
- R6: A running channel whose count is 1 or 0 when its selected tick arrives reloads the divisor and sets its raw status bit: channel 0 sets bit 0, channel 1 sets bit 1.
- R7: Writing the acknowledge register (0x24) clears every raw status bit written as 1 and leaves the other bits unchanged. An expiry in the same cycle keeps its bit set.
- R8: Masked status (0x2C) reads raw AND mask, and `irq` is high exactly when any masked bit is set, one cycle after the change that causes it.
- R9: A control write with operation 3 is ignored entirely: operation, rate and count keep their values.
- R10: Reads of unmapped offsets, and of the write-only divisor and control registers, return 0. Writes to unmapped offsets change no state.
- R11: The acknowledge register keeps no value and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_addr | input | 6 | byte offset of the accessed register |
| bus_wr | input | 1 | write strobe, one cycle per write |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for `bus_addr`, combinational |
| tick_en | input | 4 | one-cycle tick enables for rate codes 4 to 7 |
| irq | output | 1 | combined masked interrupt |

## Verification
A register write or a tick enable that is high at a rising edge takes effect at that edge. Count and status readback therefore shows the new value in the cycle after the edge. `irq` is registered from the next-state status and mask, so it changes at the same edge as the status. The bench drives writes and ticks on falling edges, holds each for exactly one rising edge, and reads on the following falling edge, where the combinational read path has settled. Every stimulus is therefore checked one cycle after it.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int NUM_CH    = 2;
    localparam int NUM_RATES = 4;
    localparam int RATE_W    = 3;
    localparam int RATE_BASE = 4;
    localparam int OP_W      = 2;
    localparam int CH_STRIDE = 16;

    localparam logic [ADDR_W-1:0] OFS_DIV    = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 6'h2C;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD    = 2'd0,
        OP_HOLD    = 2'd1,
        OP_RUN     = 2'd2,
        OP_ILLEGAL = 2'd3
    } op_e;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } chan_state_e;
endpackage

// File: rtl/dit_channel.sv
module dit_channel
    import dit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 div_wr,
    input  logic                 ctrl_wr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_RATES-1:0] tick_en,
    output logic [CNT_W-1:0]     count,
    output logic                 running,
    output logic [RATE_W-1:0]    rate,
    output logic                 expire
);
    chan_state_e         state_q, state_d;
    logic [CNT_W-1:0]    div_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [RATE_W-1:0]   rate_q;
    op_e                 op_in;
    logic                ctrl_ok;
    logic                tick_sel;

    assign op_in   = op_e'(wdata[OP_W-1:0]);
    assign ctrl_ok = ctrl_wr && (op_in != OP_ILLEGAL);

    // rate selection: code RATE_BASE+i picks tick_en[i]; others pick nothing
    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (rate_q == RATE_W'(RATE_BASE + i)) tick_sel = tick_en[i];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (ctrl_ok && op_in == OP_RUN) state_d = ST_RUNNING;
            ST_RUNNING: if (ctrl_ok && op_in != OP_RUN) state_d = ST_STOPPED;
            default:    state_d = ST_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // expiry: a control write pre-empts tick processing in its cycle
    assign expire = (state_q == ST_RUNNING) && tick_sel && !ctrl_ok && (cnt_q <= CNT_W'(1));

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            cnt_q  <= '0;
            rate_q <= '0;
        end else begin
            if (div_wr) div_q <= wdata[CNT_W-1:0];
            if (ctrl_ok) begin
                rate_q <= wdata[OP_W +: RATE_W];
                if (op_in == OP_LOAD) cnt_q <= div_q;
            end else if (state_q == ST_RUNNING && tick_sel) begin
                if (expire) cnt_q <= div_q;
                else        cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign count   = cnt_q;
    assign running = (state_q == ST_RUNNING);
    assign rate    = rate_q;
endmodule

// File: rtl/dit_irq_ctrl.sv
module dit_irq_ctrl
    import dit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] expire,
    input  logic              ack_wr,
    input  logic              mask_wr,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] raw,
    output logic [NUM_CH-1:0] mask,
    output logic              irq
);
    logic [NUM_CH-1:0] raw_q, raw_d, mask_q, mask_d;
    logic              irq_q;

    always_comb begin
        raw_d  = raw_q;
        mask_d = mask_q;
        if (ack_wr)  raw_d  = raw_d & ~wbits;
        raw_d = raw_d | expire;            // new expiry wins over acknowledge
        if (mask_wr) mask_d = wbits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            raw_q  <= raw_d;
            mask_q <= mask_d;
            irq_q  <= |(raw_d & mask_d);
        end
    end

    assign raw  = raw_q;
    assign mask = mask_q;
    assign irq  = irq_q;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_RATES-1:0] tick_en,
    output logic                 irq
);
    logic [CNT_W-1:0]  ch_count [NUM_CH];
    logic [RATE_W-1:0] ch_rate  [NUM_CH];
    logic [NUM_CH-1:0] ch_running;
    logic [NUM_CH-1:0] ch_expire;
    logic [NUM_CH-1:0] ch_div_wr;
    logic [NUM_CH-1:0] ch_ctrl_wr;
    logic [NUM_CH-1:0] raw_st, mask_st;
    logic              ack_wr, mask_wr;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam logic [ADDR_W-1:0] BASE = ADDR_W'(c * CH_STRIDE);
            assign ch_div_wr[c]  = bus_wr && (bus_addr == BASE + OFS_DIV);
            assign ch_ctrl_wr[c] = bus_wr && (bus_addr == BASE + OFS_CTRL);

            dit_channel #(.CNT_W(CNT_W)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .div_wr  (ch_div_wr[c]),
                .ctrl_wr (ch_ctrl_wr[c]),
                .wdata   (bus_wdata),
                .tick_en (tick_en),
                .count   (ch_count[c]),
                .running (ch_running[c]),
                .rate    (ch_rate[c]),
                .expire  (ch_expire[c])
            );
        end
    endgenerate

    assign ack_wr  = bus_wr && (bus_addr == OFS_ACK);
    assign mask_wr = bus_wr && (bus_addr == OFS_MASK);

    dit_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (ch_expire),
        .ack_wr  (ack_wr),
        .mask_wr (mask_wr),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .raw     (raw_st),
        .mask    (mask_st),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(c * CH_STRIDE) + OFS_COUNT)
                bus_rdata = DATA_W'(ch_count[c]);
        end
        unique case (bus_addr)
            OFS_MASK:   bus_rdata = DATA_W'(mask_st);
            OFS_RAW:    bus_rdata = DATA_W'(raw_st);
            OFS_MASKED: bus_rdata = DATA_W'(raw_st & mask_st);
            default:    ;
        endcase
    end
endmodule

// File: rtl/dit_checker.sv
module dit_checker
    import dit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt0,
    input logic              run0,
    input logic [RATE_W-1:0] rate0,
    input logic [NUM_CH-1:0] ctrl_wr,
    input logic [NUM_CH-1:0] expire,
    input logic [NUM_CH-1:0] raw,
    input logic [NUM_CH-1:0] mask,
    input logic              ack_wr,
    input logic [DATA_W-1:0] wdata
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !ctrl_wr[0]) |=> $stable(cnt0)); // R3

    AST_DISABLED_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run0 && rate0 < RATE_W'(RATE_BASE) && !ctrl_wr[0]) |=> $stable(cnt0)); // R5

    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        expire[0] |=> raw[0]); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && wdata[0] && !expire[0]) |=> !raw[0]); // R7

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & mask) != '0)); // R8

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & mask) != '0) |-> irq); // R8
endmodule

bind dual_interval_timer dit_checker #(.CNT_W(CNT_W)) u_dit_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .cnt0    (ch_count[0]),
    .run0    (ch_running[0]),
    .rate0   (ch_rate[0]),
    .ctrl_wr (ch_ctrl_wr),
    .expire  (ch_expire),
    .raw     (raw_st),
    .mask    (mask_st),
    .ack_wr  (ack_wr),
    .wdata   (bus_wdata)
);

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_en = '0;
    logic        irq;
    int checks = 0;
    int fails  = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 6'h3F;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic tick(input logic [3:0] t, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = t;
            @(negedge clk);
            tick_en = '0;
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 cnt0", 6'h08, 0);
        rd_chk("R1 cnt1", 6'h18, 0);
        rd_chk("R1 raw", 6'h28, 0);
        rd_chk("R1 mask", 6'h20, 0);
        check("R1 irq", {31'b0, irq}, 0);
        tick(4'hF, 2);
        rd_chk("R1 stopped", 6'h08, 0);
    endtask

    task automatic t_load_hold;
        wr(6'h00, 5);
        rd_chk("R2 div alone", 6'h08, 0);
        wr(6'h04, (4 << 2) | 0);
        rd_chk("R2 load", 6'h08, 5);
        tick(4'b0001, 3);
        rd_chk("R3 stopped after load", 6'h08, 5);
    endtask

    task automatic t_run;
        wr(6'h04, (4 << 2) | 2);
        tick(4'b0001, 2);
        rd_chk("R4 run", 6'h08, 3);
        tick(4'b1110, 2);
        rd_chk("R4 other ticks", 6'h08, 3);
        wr(6'h04, (4 << 2) | 1);
        tick(4'b0001, 2);
        rd_chk("R3 hold", 6'h08, 3);
    endtask

    task automatic t_disabled;
        wr(6'h04, (1 << 2) | 2);
        tick(4'hF, 2);
        rd_chk("R5 rate1", 6'h08, 3);
        wr(6'h04, (0 << 2) | 2);
        tick(4'hF, 2);
        rd_chk("R5 rate0", 6'h08, 3);
    endtask

    task automatic t_expire;
        wr(6'h04, (4 << 2) | 2);
        tick(4'b0001, 2);
        rd_chk("R4 down to 1", 6'h08, 1);
        rd_chk("R6 not yet", 6'h28, 0);
        tick(4'b0001, 1);
        rd_chk("R6 reload", 6'h08, 5);
        rd_chk("R6 bit0", 6'h28, 1);
        check("R8 irq masked off", {31'b0, irq}, 0);
        rd_chk("R8 masked 0", 6'h2C, 0);
        wr(6'h04, (4 << 2) | 1);
    endtask

    task automatic t_mask;
        wr(6'h20, 1);
        rd_chk("R8 masked", 6'h2C, 1);
        check("R8 irq on", {31'b0, irq}, 1);
        wr(6'h20, 2);
        rd_chk("R8 masked other", 6'h2C, 0);
        check("R8 irq off", {31'b0, irq}, 0);
    endtask

    task automatic t_timer1;
        wr(6'h10, 2);
        wr(6'h14, (7 << 2) | 0);
        wr(6'h14, (7 << 2) | 2);
        tick(4'b1000, 2);
        rd_chk("R6 bit1", 6'h28, 3);
        rd_chk("R6 cnt1 reload", 6'h18, 2);
        check("R8 irq t1", {31'b0, irq}, 1);
    endtask

    task automatic t_ack;
        wr(6'h24, 1);
        rd_chk("R7 ack bit0", 6'h28, 2);
        rd_chk("R11 ack reads 0", 6'h24, 0);
        wr(6'h24, 2);
        rd_chk("R7 ack bit1", 6'h28, 0);
        check("R8 irq cleared", {31'b0, irq}, 0);
    endtask

    task automatic t_illegal;
        wr(6'h14, (4 << 2) | 3);
        tick(4'b1000, 1);
        rd_chk("R9 illegal op ignored", 6'h18, 1);
    endtask

    task automatic t_unmapped;
        wr(6'h30, 32'hFFFF_FFFF);
        rd_chk("R10 unmapped read", 6'h30, 0);
        rd_chk("R10 hole read", 6'h0C, 0);
        rd_chk("R10 ctrl read", 6'h04, 0);
        rd_chk("R10 div read", 6'h00, 0);
        rd_chk("R10 mask kept", 6'h20, 2);
        rd_chk("R10 cnt1 kept", 6'h18, 1);
        rd_chk("R10 raw kept", 6'h28, 0);
    endtask

    initial begin
        fork
            begin : watchdog
                repeat (20000) @(posedge clk);
                if (!done) begin
                    fails++;
                    checks++;
                    $display("FAIL watchdog actual=running expected=done");
                    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                    $finish;
                end
            end
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_load_hold;
        t_run;
        t_disabled;
        t_expire;
        t_mask;
        t_timer1;
        t_ack;
        t_illegal;
        t_unmapped;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule